// File: doc/BRIEF.md
# NAND Sector Hamming ECC Accumulator

This block sits beside the data path of a NAND flash controller. It builds a Hamming parity code from each byte as the byte crosses the flash bus, in either direction, so no separate pass over the data is needed. Software sets the sector size, raises the enable bit, and then moves a sector of data. When the sector is complete, the code is read from the result register and compared with the parity kept in the spare area. That comparison and any correction are done by software.

Each byte goes through a one-cycle capture stage before it is folded into the code. A write-pending status stays high while a captured byte is still waiting to be folded, so software can tell when the code is final. After the programmed number of bytes has been folded, the block sets a done flag, freezes the code, and ignores any further bytes. The code and the done flag clear only when the enable bit is dropped. A new sector starts when the enable bit is raised again.

Top module: `nand_ecc_acc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ecc_result` is 0 and both `sector_done` and `write_pending` are 0.
- R2: Let g = 8*(byte index within the sector) + (bit position within the byte), where the first accepted byte has index 0. For each i below L, result bit 2i+1 is the XOR of all accepted data bits whose g has bit i set, and result bit 2i is the XOR of all accepted data bits whose g has bit i clear.
- R3: Sector-size codes 0 to 5 select 256<<code bytes, and codes 6 and 7 both select 8192 bytes. L is log2(bytes)+3. Result bits 2L and above always read 0.
- R4: A byte is accepted on a rising edge where `ecc_en` and `byte_vld` are high and the sector is not yet full. Its contribution appears in `ecc_result` after the following rising edge.
- R5: `write_pending` is high for exactly the cycle between a byte's acceptance and the edge that folds it into the code.
- R6: `sector_done` rises on the edge that folds the last byte of the sector. It then stays high while `ecc_en` stays high.
- R7: Once the configured number of bytes has been accepted, further strobes are ignored. `ecc_result` does not change and `write_pending` stays low.
- R8: A rising edge with `ecc_en` low clears the result, the done flag, the pending stage and the byte count. Strobes arriving while `ecc_en` is low are ignored.
- R9: `size_code` is captured on each edge where `ecc_en` is low. Changes to it while `ecc_en` is high have no effect on the sector in progress.
- R10: Cycles with `byte_vld` low, including gaps in the middle of a sector, leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Enable; low clears the block and captures the sector size |
| size_code | input | 3 | Sector-size selection |
| byte_vld | input | 1 | A data byte is on `byte_data` this cycle |
| byte_data | input | 8 | Byte seen on the flash data bus |
| ecc_result | output | 32 | Accumulated Hamming code, upper bits masked |
| sector_done | output | 1 | Last byte of the sector has been folded |
| write_pending | output | 1 | A captured byte has not yet been folded |

## Verification
A strobe sampled at edge N raises `write_pending` after edge N. It lands in `ecc_result` after edge N+1. If it was the last byte of the sector, `sector_done` also rises after edge N+1. A low enable at edge N shows as cleared outputs after edge N. The bench drives inputs on falling edges and advances a behavioural model on each rising edge, using the same inputs the design sees. It then compares all three outputs against that model on the next falling edge, so every one of these latencies is checked in every cycle. Directed sequences cover strobes after a full sector, mid-sector disable, size changes while enabled, each size class, and a single-bit pattern whose code is known in closed form.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int SECT_MIN_LOG2 = 8;
    localparam int SECT_MAX_LOG2 = 13;
    localparam int SIZE_CODE_W   = 3;
    localparam int BYTE_W        = 8;
    localparam int BIT_IDX_W     = $clog2(BYTE_W);
    localparam int ADDR_W        = SECT_MAX_LOG2;
    localparam int CNT_W         = SECT_MAX_LOG2 + 1;
    localparam int COL_W         = 2 * BIT_IDX_W;
    localparam int LINE_W        = 2 * ADDR_W;
    localparam int ECC_W         = LINE_W + COL_W;

    typedef logic [SIZE_CODE_W-1:0] size_code_t;

    // One captured bus byte with its position in the sector
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [ADDR_W-1:0] addr;
        logic              last;
    } ecc_beat_t;

    // Parity code: byte-address terms above, bit-position terms below
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
    } ecc_code_t;

    function automatic int addr_log2(size_code_t code);
        int w;
        w = SECT_MIN_LOG2 + int'(code);
        if (w > SECT_MAX_LOG2) w = SECT_MAX_LOG2;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] sector_len(size_code_t code);
        return CNT_W'(1) << addr_log2(code);
    endfunction

    function automatic logic [ECC_W-1:0] code_mask(size_code_t code);
        logic [ECC_W:0] m;
        m = ((ECC_W+1)'(1) << (2 * (addr_log2(code) + BIT_IDX_W))) - (ECC_W+1)'(1);
        return m[ECC_W-1:0];
    endfunction

    // Odd term for positions with bit k set, even term for bit k clear
    function automatic logic [COL_W-1:0] column_terms(logic [BYTE_W-1:0] d);
        logic [COL_W-1:0] t;
        t = '0;
        for (int k = 0; k < BIT_IDX_W; k++) begin
            for (int b = 0; b < BYTE_W; b++) begin
                if (((b >> k) & 1) == 1) t[2*k+1] = t[2*k+1] ^ d[b];
                else                     t[2*k]   = t[2*k]   ^ d[b];
            end
        end
        return t;
    endfunction

    function automatic logic [LINE_W-1:0] line_terms(logic [ADDR_W-1:0] a, logic bp);
        logic [LINE_W-1:0] t;
        for (int j = 0; j < ADDR_W; j++) begin
            t[2*j+1] = bp & a[j];
            t[2*j]   = bp & ~a[j];
        end
        return t;
    endfunction

endpackage

// File: rtl/nand_ecc_sector_ctl.sv
module nand_ecc_sector_ctl
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  size_code_t        size_code,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output size_code_t        size_q,
    output logic              beat_vld,
    output ecc_beat_t         beat
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             full;
    logic             accept;

    assign limit  = sector_len(size_q);
    assign full   = (cnt == limit);
    assign accept = ecc_en & byte_vld & ~full;

    always_ff @(posedge clk) begin
        if (rst)         size_q <= '0;
        else if (!ecc_en) size_q <= size_code;
    end

    always_ff @(posedge clk) begin
        if (rst || !ecc_en) begin
            cnt      <= '0;
            beat_vld <= 1'b0;
            beat     <= '0;
        end else begin
            beat_vld <= accept;
            if (accept) begin
                beat.data <= byte_data;
                beat.addr <= cnt[ADDR_W-1:0];
                beat.last <= (cnt == limit - CNT_W'(1));
                cnt       <= cnt + CNT_W'(1);
            end
        end
    end

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);                                          // R7
    AST_SIZE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ecc_en |=> $stable(size_q));                            // R9
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !ecc_en |=> (cnt == '0 && !beat_vld));                  // R8

endmodule

// File: rtl/nand_ecc_fold.sv
module nand_ecc_fold
    import nand_ecc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ecc_en,
    input  logic      beat_vld,
    input  ecc_beat_t beat,
    output ecc_code_t acc,
    output logic      done
);

    logic byte_par;

    assign byte_par = ^beat.data;

    always_ff @(posedge clk) begin
        if (rst || !ecc_en) begin
            acc  <= '0;
            done <= 1'b0;
        end else if (beat_vld) begin
            acc.line <= acc.line ^ line_terms(beat.addr, byte_par);
            acc.col  <= acc.col ^ column_terms(beat.data);
            if (beat.last) done <= 1'b1;
        end
    end

    AST_ACC_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ecc_en && !beat_vld) |=> $stable(acc));                // R10
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && ecc_en) |=> done);                             // R6

endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
    import nand_ecc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ecc_en,
    input  logic [SIZE_CODE_W-1:0] size_code,
    input  logic                   byte_vld,
    input  logic [BYTE_W-1:0]      byte_data,
    output logic [ECC_W-1:0]       ecc_result,
    output logic                   sector_done,
    output logic                   write_pending
);

    size_code_t size_q;
    logic       beat_vld;
    ecc_beat_t  beat;
    ecc_code_t  acc;
    logic       done;

    nand_ecc_sector_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ecc_en    (ecc_en),
        .size_code (size_code),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .size_q    (size_q),
        .beat_vld  (beat_vld),
        .beat      (beat)
    );

    nand_ecc_fold u_fold (
        .clk      (clk),
        .rst      (rst),
        .ecc_en   (ecc_en),
        .beat_vld (beat_vld),
        .beat     (beat),
        .acc      (acc),
        .done     (done)
    );

    assign ecc_result    = acc & code_mask(size_q);
    assign sector_done   = done;
    assign write_pending = beat_vld;

    AST_DONE_NOTHING_PENDING: assert property (@(posedge clk) disable iff (rst)
        sector_done |-> !write_pending);                        // R7
    AST_ENABLE_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !ecc_en |=> (ecc_result == '0 && !sector_done));        // R8

endmodule

// File: tb/tb_nand_ecc_acc.sv
module tb_nand_ecc_acc;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ecc_en = 1'b0;
    logic [2:0]  size_code = 3'd0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [31:0] ecc_result;
    logic        sector_done;
    logic        write_pending;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R1";
    int unsigned seed = 32'h1234_5678;
    bit    finished = 0;

    nand_ecc_acc dut (
        .clk           (clk),
        .rst           (rst),
        .ecc_en        (ecc_en),
        .size_code     (size_code),
        .byte_vld      (byte_vld),
        .byte_data     (byte_data),
        .ecc_result    (ecc_result),
        .sector_done   (sector_done),
        .write_pending (write_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural model ----------------
    int          m_cnt, m_size, m_addr;
    bit          m_pend, m_last, m_done;
    logic [7:0]  m_byte;
    logic [31:0] m_ecc;

    function automatic int len_of(int code);
        return (code > 5) ? 8192 : (256 << code);
    endfunction

    function automatic int log2_of(int n);
        int r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_size = 0; m_pend = 0; m_done = 0; m_ecc = '0;
        end else if (!ecc_en) begin
            m_cnt = 0; m_pend = 0; m_done = 0; m_ecc = '0;
            m_size = int'(size_code);
        end else begin
            if (m_pend) begin
                int nbits;
                nbits = log2_of(len_of(m_size)) + 3;
                for (int b = 0; b < 8; b++) begin
                    int g;
                    g = m_addr * 8 + b;
                    for (int i = 0; i < nbits; i++) begin
                        if (((g >> i) & 1) == 1) m_ecc[2*i+1] = m_ecc[2*i+1] ^ m_byte[b];
                        else                     m_ecc[2*i]   = m_ecc[2*i]   ^ m_byte[b];
                    end
                end
                if (m_last) m_done = 1;
                m_pend = 0;
            end
            if (byte_vld && m_cnt < len_of(m_size)) begin
                m_pend = 1;
                m_byte = byte_data;
                m_addr = m_cnt;
                m_last = (m_cnt == len_of(m_size) - 1);
                m_cnt++;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!finished) begin
            n_checks++;
            if (ecc_result !== m_ecc) begin
                n_fail++;
                $display("FAIL R2 %s ecc_result actual=%h expected=%h", cur_tag, ecc_result, m_ecc);
            end
            n_checks++;
            if (sector_done !== m_done) begin
                n_fail++;
                $display("FAIL R6 %s sector_done actual=%b expected=%b", cur_tag, sector_done, m_done);
            end
            n_checks++;
            if (write_pending !== m_pend) begin
                n_fail++;
                $display("FAIL R5 %s write_pending actual=%b expected=%b", cur_tag, write_pending, m_pend);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [7:0] next_rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    task automatic push(input logic [7:0] d);
        byte_vld  = 1'b1;
        byte_data = d;
        @(negedge clk);
        byte_vld  = 1'b0;
    endtask

    task automatic idle(input int n);
        byte_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [2:0] code);
        ecc_en    = 1'b0;
        size_code = code;
        idle(2);
        ecc_en = 1'b1;
    endtask

    task automatic stream(input int n, input int gap_every);
        for (int k = 0; k < n; k++) begin
            push(next_rnd());
            if (gap_every > 0 && (k % gap_every) == gap_every - 1) idle(2);
        end
    endtask

    task automatic directed(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ecc_result actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] snap;
        logic [31:0] exp_bit;
        int g;

        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Full 256-byte sector with gaps
        cur_tag = "R4 R10";
        restart(3'd0);
        stream(256, 7);
        idle(3);

        // Strobes after the sector is full
        cur_tag = "R7";
        snap = ecc_result;
        stream(5, 0);
        idle(2);
        directed("R7 frozen after full sector", ecc_result, snap);

        // Disable with strobes present
        cur_tag = "R8";
        ecc_en = 1'b0;
        stream(4, 0);
        idle(1);
        directed("R8 cleared by enable low", ecc_result, 32'h0);

        // Size change while enabled
        cur_tag = "R9 R3";
        restart(3'd1);
        stream(200, 0);
        size_code = 3'd0;
        stream(312, 13);
        idle(3);

        // Mid-sector disable
        cur_tag = "R8";
        restart(3'd2);
        stream(100, 0);
        byte_vld  = 1'b1;
        byte_data = 8'h5A;
        ecc_en    = 1'b0;
        @(negedge clk);
        byte_vld = 1'b0;
        idle(2);

        // Largest sizes and reserved code
        cur_tag = "R3";
        restart(3'd7);
        stream(8192, 0);
        idle(3);
        restart(3'd6);
        stream(300, 0);
        idle(2);
        restart(3'd3);
        stream(50, 5);
        idle(2);

        // Single set bit at byte 37, bit 4
        cur_tag = "R2";
        restart(3'd0);
        for (int k = 0; k < 256; k++) push((k == 37) ? 8'h10 : 8'h00);
        idle(2);
        g = 37 * 8 + 4;
        exp_bit = '0;
        for (int i = 0; i < 11; i++) begin
            if (((g >> i) & 1) == 1) exp_bit[2*i+1] = 1'b1;
            else                     exp_bit[2*i]   = 1'b1;
        end
        directed("R2 single-bit code", ecc_result, exp_bit);

        // Back-to-back bytes
        cur_tag = "R4 R5";
        restart(3'd0);
        stream(256, 0);
        idle(3);

        finish_run();
    end

endmodule